// File: doc/BRIEF.md
# Per-Source Event Gate with Pending/Queued Coalescing

This block sits between a set of interrupt sources and a downstream routing stage. For each of `NUM_SRC` sources it holds a two-bit state: a pending bit and a queued bit. An incoming trigger names one source. The state of that source decides whether the trigger becomes a notification to the router, is folded into an event that is already outstanding, or is dropped because the source is switched off. Repeated triggers that arrive while an event is being serviced are merged into a single queued repeat. That repeat is replayed as a fresh notification when software signals end-of-interrupt.

Software reaches the state array through a narrow register port that addresses one source at a time. Three operations are available: a plain load, a write of a new two-bit value that returns the old value in the same cycle, and an end-of-interrupt. Notifications leave the block as a one-cycle strobe with the source index. When a trigger notification and a replayed notification fall in the same cycle, the replay waits in a per-source flag until the strobe is free.

Top module: `pq_event_gate`

## Requirements
- R1: After reset every source is in state 01 (off), and `notify_valid` is low.
- R2: A trigger on a source in state 00 (idle) moves it to 10 (pending) and raises `notify_valid` for one cycle, in the cycle after the trigger, with `notify_src` equal to that source.
- R3: A trigger on a source in state 10 moves it to 11 (pending with a queued repeat). A trigger on 11 leaves it at 11. Neither produces a notification.
- R4: A trigger on a source in state 01 leaves the state at 01 and produces no notification.
- R5: End-of-interrupt (`mmio_op` = 2'b10) on a source in state 10 returns it to 00 with no notification. On state 00 or 01 it changes nothing.
- R6: End-of-interrupt on a source in state 11 moves it to 10 and issues a new notification for that source. When no trigger notification competes, the notification appears in the cycle after the operation.
- R7: `mmio_op` = 2'b01 writes `mmio_wdata` into the addressed source, and `mmio_rdata` shows the value held before the write in the same cycle. `mmio_op` = 2'b00 or 2'b11 returns the current value on `mmio_rdata` and changes nothing. End-of-interrupt also returns the prior value.
- R8: When a register operation and a trigger address the same source in the same cycle, the register operation is applied first and the trigger then acts on the result.
- R9: At most one notification leaves per cycle, and a trigger notification has priority. A replay that loses is held and sent in a later cycle with no trigger notification. Held replays are sent lowest source index first. A write to a source cancels that source's held replay.
- R10: An operation or trigger on one source leaves the state of every other source unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| trig_valid | input | 1 | A trigger for `trig_src` is present this cycle |
| trig_src | input | SRC_W | Source index of the trigger |
| mmio_valid | input | 1 | A register operation is present this cycle |
| mmio_src | input | SRC_W | Source addressed by the register operation |
| mmio_op | input | 2 | 00 load, 01 write, 10 end-of-interrupt, 11 load |
| mmio_wdata | input | 2 | New state for a write |
| mmio_rdata | output | 2 | State of the addressed source before this cycle's update |
| notify_valid | output | 1 | One-cycle notification strobe |
| notify_src | output | SRC_W | Source index carried by the notification |

## Verification
The bench looks first at the coalescing path, where a trigger on a pending source must not notify. A design that re-notified there would flood the router with a second strobe. Replay at end-of-interrupt is checked for both the notification and the drop from 11 to 10. A design that cleared the queued bit without notifying would silently lose an event. Same-cycle collisions are forced on purpose: register-then-trigger on one source, where the wrong order leaves a stale state or a missing strobe, and a replay against a trigger on another source, where a wrong design drops the replay, emits two indices in the wrong order, or sends a replay that a following write should have cancelled.

// File: rtl/pq_event_gate_pkg.sv
package pq_event_gate_pkg;

  typedef enum logic [1:0] {
    PQ_IDLE   = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_state_e;

  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_SET  = 2'b01,
    OP_EOI  = 2'b10,
    OP_PEEK = 2'b11
  } pq_op_e;

  localparam pq_state_e PQ_RESET = PQ_OFF;

endpackage

// File: rtl/pq_event_cell.sv
module pq_event_cell
  import pq_event_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mmio_hit,
  input  logic [1:0] mmio_op,
  input  logic [1:0] mmio_wdata,
  input  logic       trig_hit,
  output pq_state_e  state_q,
  output logic       trig_notify,
  output logic       replay_now
);

  pq_state_e state_mid;
  pq_state_e state_d;
  logic      upd_en;

  // Register operation first, then the trigger on its result.
  always_comb begin
    state_mid  = state_q;
    replay_now = 1'b0;
    if (mmio_hit) begin
      unique case (pq_op_e'(mmio_op))
        OP_SET: state_mid = pq_state_e'(mmio_wdata);
        OP_EOI: begin
          if (state_q == PQ_PEND) begin
            state_mid = PQ_IDLE;
          end else if (state_q == PQ_QUEUED) begin
            state_mid  = PQ_PEND;
            replay_now = 1'b1;
          end
        end
        default: state_mid = state_q;
      endcase
    end

    state_d     = state_mid;
    trig_notify = 1'b0;
    if (trig_hit) begin
      unique case (state_mid)
        PQ_IDLE: begin
          state_d     = PQ_PEND;
          trig_notify = 1'b1;
        end
        PQ_PEND: state_d = PQ_QUEUED;
        default: state_d = state_mid;
      endcase
    end
  end

  assign upd_en = mmio_hit | trig_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PQ_RESET;
    end else if (upd_en) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/pq_event_arb.sv
module pq_event_arb #(
  parameter int NUM_REQ = 16,
  parameter int IDX_W   = 4
) (
  input  logic [NUM_REQ-1:0] req,
  input  logic               en,
  output logic               gnt_valid,
  output logic [IDX_W-1:0]   gnt_idx,
  output logic [NUM_REQ-1:0] gnt_oh
);

  logic               any_req;
  logic [IDX_W-1:0]   low_idx;
  logic [NUM_REQ-1:0] low_oh;

  // Descending scan: the last hit, the lowest index, wins.
  always_comb begin
    any_req = 1'b0;
    low_idx = '0;
    low_oh  = '0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        any_req   = 1'b1;
        low_idx   = IDX_W'(i);
        low_oh    = '0;
        low_oh[i] = 1'b1;
      end
    end
  end

  assign gnt_valid = en & any_req;
  assign gnt_idx   = low_idx;
  assign gnt_oh    = en ? low_oh : '0;

endmodule

// File: rtl/pq_event_gate.sv
module pq_event_gate
  import pq_event_gate_pkg::*;
#(
  parameter int NUM_SRC = 16,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_valid,
  input  logic [SRC_W-1:0] trig_src,
  input  logic             mmio_valid,
  input  logic [SRC_W-1:0] mmio_src,
  input  logic [1:0]       mmio_op,
  input  logic [1:0]       mmio_wdata,
  output logic [1:0]       mmio_rdata,
  output logic             notify_valid,
  output logic [SRC_W-1:0] notify_src
);

  logic [NUM_SRC-1:0][1:0] state_vec;
  logic [NUM_SRC-1:0]      trig_oh;
  logic [NUM_SRC-1:0]      mmio_oh;
  logic [NUM_SRC-1:0]      set_oh;
  logic [NUM_SRC-1:0]      trig_note_vec;
  logic [NUM_SRC-1:0]      replay_now_vec;
  logic [NUM_SRC-1:0]      replay_q;
  logic [NUM_SRC-1:0]      replay_d;
  logic [NUM_SRC-1:0]      replay_req;
  logic [NUM_SRC-1:0]      gnt_oh;
  logic                    gnt_valid;
  logic [SRC_W-1:0]        gnt_idx;
  logic                    trig_note;
  logic                    note_valid_d;
  logic [SRC_W-1:0]        note_src_d;
  logic                    mmio_in_range;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pq_state_e cell_state;

    assign trig_oh[g] = trig_valid && (int'(trig_src) == g);
    assign mmio_oh[g] = mmio_valid && (int'(mmio_src) == g);
    assign set_oh[g]  = mmio_oh[g] && (pq_op_e'(mmio_op) == OP_SET);

    pq_event_cell cell_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .mmio_hit    (mmio_oh[g]),
      .mmio_op     (mmio_op),
      .mmio_wdata  (mmio_wdata),
      .trig_hit    (trig_oh[g]),
      .state_q     (cell_state),
      .trig_notify (trig_note_vec[g]),
      .replay_now  (replay_now_vec[g])
    );

    assign state_vec[g] = cell_state;
  end

  assign mmio_in_range = int'(mmio_src) < NUM_SRC;
  assign mmio_rdata    = (mmio_valid && mmio_in_range) ? state_vec[mmio_src] : 2'b00;

  assign trig_note  = |trig_note_vec;
  assign replay_req = (replay_q & ~set_oh) | replay_now_vec;

  pq_event_arb #(
    .NUM_REQ (NUM_SRC),
    .IDX_W   (SRC_W)
  ) arb_i (
    .req       (replay_req),
    .en        (!trig_note),
    .gnt_valid (gnt_valid),
    .gnt_idx   (gnt_idx),
    .gnt_oh    (gnt_oh)
  );

  always_comb begin
    replay_d     = replay_req & ~gnt_oh;
    note_valid_d = trig_note | gnt_valid;
    note_src_d   = trig_note ? trig_src : gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      replay_q     <= '0;
      notify_valid <= 1'b0;
      notify_src   <= '0;
    end else begin
      replay_q     <= replay_d;
      notify_valid <= note_valid_d;
      if (note_valid_d) begin
        notify_src <= note_src_d;
      end
    end
  end

endmodule

// File: rtl/pq_event_gate_chk.sv
module pq_event_gate_chk #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trig_valid,
  input logic [SRC_W-1:0]        trig_src,
  input logic                    mmio_valid,
  input logic [SRC_W-1:0]        mmio_src,
  input logic [1:0]              mmio_op,
  input logic [1:0]              mmio_wdata,
  input logic                    notify_valid,
  input logic [SRC_W-1:0]        notify_src,
  input logic [NUM_SRC-1:0][1:0] state_vec
);

  logic trig_alone;
  logic mmio_alone;

  assign trig_alone = trig_valid && (int'(trig_src) < NUM_SRC) &&
                      !(mmio_valid && mmio_src == trig_src);
  assign mmio_alone = mmio_valid && (int'(mmio_src) < NUM_SRC) &&
                      !(trig_valid && trig_src == mmio_src);

  // R2
  idle_trig_notifies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_alone && state_vec[trig_src] == 2'b00
    |=> notify_valid && notify_src == $past(trig_src));

  // R3
  pend_trig_queues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_alone && state_vec[trig_src] == 2'b10
    |=> state_vec[$past(trig_src)] == 2'b11);

  // R4
  off_trig_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_alone && state_vec[trig_src] == 2'b01
    |=> state_vec[$past(trig_src)] == 2'b01);

  // R6
  eoi_queued_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_alone && mmio_op == 2'b10 && state_vec[mmio_src] == 2'b11
    |=> state_vec[$past(mmio_src)] == 2'b10);

  // R7
  set_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mmio_alone && mmio_op == 2'b01
    |=> state_vec[$past(mmio_src)] == $past(mmio_wdata));

  // R9
  notify_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> int'(notify_src) < NUM_SRC);

endmodule

bind pq_event_gate pq_event_gate_chk #(
  .NUM_SRC (NUM_SRC),
  .SRC_W   (SRC_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_valid   (trig_valid),
  .trig_src     (trig_src),
  .mmio_valid   (mmio_valid),
  .mmio_src     (mmio_src),
  .mmio_op      (mmio_op),
  .mmio_wdata   (mmio_wdata),
  .notify_valid (notify_valid),
  .notify_src   (notify_src),
  .state_vec    (state_vec)
);

// File: tb/pq_event_gate_tb_top.sv
module pq_event_gate_tb_top;

  localparam int NUM_SRC = 16;
  localparam int SRC_W   = 4;

  logic             clk;
  logic             rst_n;
  logic             trig_valid;
  logic [SRC_W-1:0] trig_src;
  logic             mmio_valid;
  logic [SRC_W-1:0] mmio_src;
  logic [1:0]       mmio_op;
  logic [1:0]       mmio_wdata;
  logic [1:0]       mmio_rdata;
  logic             notify_valid;
  logic [SRC_W-1:0] notify_src;

  int vec_cnt = 0;
  int err_cnt = 0;

  logic [1:0]       rd_cap;
  logic             nv_cap;
  logic [SRC_W-1:0] ns_cap;

  pq_event_gate #(.NUM_SRC(NUM_SRC)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig_valid   (trig_valid),
    .trig_src     (trig_src),
    .mmio_valid   (mmio_valid),
    .mmio_src     (mmio_src),
    .mmio_op      (mmio_op),
    .mmio_wdata   (mmio_wdata),
    .mmio_rdata   (mmio_rdata),
    .notify_valid (notify_valid),
    .notify_src   (notify_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp, string what);
    vec_cnt++;
    if (act != exp) begin
      err_cnt++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Drive one cycle from a falling edge; capture rdata before the rising
  // edge and the notification after it.
  task automatic cycle(bit tv, int ts, bit mv, int op, int ms, int wd);
    trig_valid = tv;
    trig_src   = SRC_W'(ts);
    mmio_valid = mv;
    mmio_op    = 2'(op);
    mmio_src   = SRC_W'(ms);
    mmio_wdata = 2'(wd);
    #1;
    rd_cap = mmio_rdata;
    @(posedge clk);
    @(negedge clk);
    trig_valid = 1'b0;
    mmio_valid = 1'b0;
    nv_cap = notify_valid;
    ns_cap = notify_src;
  endtask

  task automatic idle();
    cycle(0, 0, 0, 0, 0, 0);
  endtask

  task automatic trig(int s);
    cycle(1, s, 0, 0, 0, 0);
  endtask

  task automatic set_pq(int s, int v);
    cycle(0, 0, 1, 1, s, v);
  endtask

  task automatic eoi(int s);
    cycle(0, 0, 1, 2, s, 0);
  endtask

  task automatic expect_state(string tag, int s, int exp);
    cycle(0, 0, 1, 0, s, 0);
    chk(tag, rd_cap, exp, $sformatf("state of src %0d", s));
  endtask

  task automatic t_reset();
    for (int s = 0; s < NUM_SRC; s++) expect_state("R1", s, 1);
    chk("R1", nv_cap, 0, "notify after reset");
    trig(2);
    chk("R1", nv_cap, 0, "trigger on reset source notifies");
  endtask

  task automatic t_trigger_idle();
    set_pq(3, 0);
    chk("R7", rd_cap, 1, "write returns prior value");
    trig(3);
    chk("R2", nv_cap, 1, "notify valid");
    chk("R2", ns_cap, 3, "notify src");
    idle();
    chk("R2", nv_cap, 0, "strobe lasts one cycle");
    expect_state("R2", 3, 2);
  endtask

  task automatic t_coalesce();
    trig(3);
    chk("R3", nv_cap, 0, "notify on pending");
    expect_state("R3", 3, 3);
    trig(3);
    chk("R3", nv_cap, 0, "notify on queued");
    expect_state("R3", 3, 3);
  endtask

  task automatic t_masked();
    trig(5);
    chk("R4", nv_cap, 0, "notify on off source");
    expect_state("R4", 5, 1);
  endtask

  task automatic t_eoi_replay();
    eoi(3);
    chk("R6", rd_cap, 3, "eoi returns prior");
    chk("R6", nv_cap, 1, "replay notify valid");
    chk("R6", ns_cap, 3, "replay notify src");
    idle();
    chk("R6", nv_cap, 0, "single replay strobe");
    expect_state("R6", 3, 2);
  endtask

  task automatic t_eoi_plain();
    eoi(3);
    chk("R5", nv_cap, 0, "eoi on pending notifies");
    expect_state("R5", 3, 0);
    eoi(3);
    chk("R5", nv_cap, 0, "eoi on idle notifies");
    expect_state("R5", 3, 0);
    eoi(5);
    chk("R5", nv_cap, 0, "eoi on off notifies");
    expect_state("R5", 5, 1);
  endtask

  task automatic t_load();
    set_pq(8, 3);
    cycle(0, 0, 1, 0, 8, 0);
    chk("R7", rd_cap, 3, "load value");
    cycle(0, 0, 1, 3, 8, 0);
    chk("R7", rd_cap, 3, "op 11 load value");
    chk("R7", nv_cap, 0, "load notifies");
    expect_state("R7", 8, 3);
  endtask

  task automatic t_same_cycle();
    set_pq(7, 0);
    cycle(1, 7, 1, 1, 7, 0);
    chk("R8", nv_cap, 1, "write then trigger notifies");
    chk("R8", ns_cap, 7, "write then trigger src");
    expect_state("R8", 7, 2);
    set_pq(7, 3);
    cycle(1, 7, 1, 2, 7, 0);
    chk("R8", nv_cap, 1, "eoi then trigger replays");
    chk("R8", ns_cap, 7, "eoi then trigger src");
    expect_state("R8", 7, 3);
    set_pq(7, 0);
    cycle(1, 7, 1, 1, 7, 1);
    chk("R8", nv_cap, 0, "write off then trigger notifies");
    expect_state("R8", 7, 1);
  endtask

  task automatic t_collision();
    set_pq(2, 3);
    set_pq(9, 3);
    set_pq(4, 0);
    set_pq(6, 0);
    cycle(1, 4, 1, 2, 9, 0);
    chk("R9", nv_cap, 1, "trigger wins valid");
    chk("R9", ns_cap, 4, "trigger wins src");
    cycle(1, 6, 1, 2, 2, 0);
    chk("R9", ns_cap, 6, "second trigger wins src");
    idle();
    chk("R9", nv_cap, 1, "held replay valid");
    chk("R9", ns_cap, 2, "lowest held replay first");
    idle();
    chk("R9", nv_cap, 1, "second held replay valid");
    chk("R9", ns_cap, 9, "second held replay src");
    idle();
    chk("R9", nv_cap, 0, "held replays drained");
    set_pq(10, 3);
    set_pq(11, 0);
    cycle(1, 11, 1, 2, 10, 0);
    chk("R9", ns_cap, 11, "trigger over replay src");
    set_pq(10, 0);
    chk("R9", nv_cap, 0, "write cancels held replay");
    idle();
    chk("R9", nv_cap, 0, "cancelled replay stays gone");
  endtask

  task automatic t_isolation();
    expect_state("R10", 0, 1);
    expect_state("R10", 1, 1);
    expect_state("R10", 12, 1);
    expect_state("R10", 15, 1);
    expect_state("R10", 2, 2);
    expect_state("R10", 9, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    err_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    trig_valid = 1'b0;
    trig_src   = '0;
    mmio_valid = 1'b0;
    mmio_src   = '0;
    mmio_op    = '0;
    mmio_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", notify_valid, 0, "notify during reset");
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_trigger_idle();
    t_coalesce();
    t_masked();
    t_eoi_replay();
    t_eoi_plain();
    t_load();
    t_same_cycle();
    t_collision();
    t_isolation();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
    $finish;
  end

endmodule